// File: doc/BRIEF.md
# Atomic Set/Clear Peripheral Register Bank

This block is the register front end of a peripheral that sits on a 32-bit, word-only peripheral bus. Software can change any single bit of its state without a read-modify-write sequence. Each writable bit vector has two addresses: one where writing a one sets a bit and one where writing a one clears it. Zero bits in a write leave the state unchanged, so an interrupted handler cannot corrupt a bit that another context owns.

The bank holds five pieces of state:
- a command register that produces a one-cycle pulse for each bit written as one;
- a plain read/write mode register;
- a feature-enable vector;
- an event status vector that hardware sets from event inputs and software clears;
- an interrupt mask.

The interrupt line is high when any event status bit is one and its mask bit is also one. The peripheral function behind these registers and the interrupt controller that receives the line are outside this block.

Accesses use a byte address. The two lowest address bits are dropped, so a byte or half-word access acts on the whole word. Reads are combinational from the registers. Writes take effect at the clock edge where the write is presented.

Top module: `setclr_regbank`

## Requirements
- R1: A write to word offset 0x00 latches a command pulse on `cmd_pulse`. It is high for exactly the one cycle after the write edge, for each bit written as one, and is zero otherwise. A read of offset 0x00 returns zero.
- R2: Word offset 0x04 is a read/write mode register. It stores the low MODE_W bits of the write data, drives `mode_o`, and reads back at the same offset.
- R3: Writing ones to offset 0x08 sets the matching feature-enable bits, and writing ones to offset 0x0C clears them. Zero bits are ignored. The vector reads back at offset 0x10 and drives `feat_en`.
- R4: An event status bit is set at any clock edge where its `evt_in` bit is high. Writing ones to offset 0x18 clears the matching bits, and zero bits are ignored. The vector reads back at offset 0x14. If an event and a clear hit the same bit at the same edge, the bit ends up set.
- R5: Writing ones to offset 0x1C sets interrupt mask bits, and writing ones to offset 0x20 clears them. Zero bits are ignored. The mask reads back only at offset 0x24.
- R6: `irq` is high exactly when some bit is one in both the event status and the interrupt mask. It follows register changes in the cycle after the edge that made them.
- R7: Address bits [1:0] are ignored, so any byte address inside a word selects that whole word.
- R8: Register bits above each vector's width read as zero, and writes to them are ignored. Reads of the write-only offsets (0x00, 0x08, 0x0C, 0x18, 0x1C, 0x20) and of unmapped offsets return zero. Writes to the read-only offsets (0x10, 0x14, 0x24) and to unmapped offsets change nothing.
- R9: After reset, every register, `cmd_pulse`, `feat_en`, `mode_o` and `irq` are zero.
- R10: `bus_rdata` is zero whenever no read is presented, that is when `bus_sel` is low or `bus_wr` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access presented this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is presented |
| evt_in | input | EVT_W (8) | Hardware event inputs that set event status bits |
| cmd_pulse | output | CMD_W (4) | One-cycle command pulses |
| mode_o | output | MODE_W (8) | Current mode register value |
| feat_en | output | FEAT_W (8) | Current feature-enable vector |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the collision between a hardware event and a software clear on the same status bit at the same edge. The bench reaches it by raising `evt_in` in the same cycle as the clear write, then reading the status word back to confirm the bit survived. Masking is exercised in the reverse direction as well: the mask is removed while the event stays pending, and `irq` must drop without the status changing. It is then re-enabled, and `irq` must come back.

// File: rtl/setclr_pkg.sv
package setclr_pkg;
  // Word offsets; the bus byte address is this value times four.
  typedef enum logic [3:0] {
    RG_CMD   = 4'd0,
    RG_MODE  = 4'd1,
    RG_FSET  = 4'd2,
    RG_FCLR  = 4'd3,
    RG_FSTAT = 4'd4,
    RG_EVST  = 4'd5,
    RG_EVCLR = 4'd6,
    RG_MSET  = 4'd7,
    RG_MCLR  = 4'd8,
    RG_MASK  = 4'd9
  } reg_e;
  localparam int NUM_REGS = 10;
  localparam int BUS_W    = 32;
endpackage

// File: rtl/setclr_decode.sv
module setclr_decode
  import setclr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_REGS-1:0] wr_stb_o,
  output logic              rd_hit_o,
  output reg_e              rd_reg_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             in_map;
  logic             unused_lowbits;

  // Byte/half-word accesses are widened: the low two address bits are dropped.
  assign idx            = addr_i[ADDR_W-1:2];
  assign unused_lowbits = ^addr_i[1:0];
  assign in_map         = (idx < IDX_W'(NUM_REGS));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wstb
    assign wr_stb_o[g] = sel_i & wr_i & (idx == IDX_W'(g));
  end

  assign rd_hit_o = sel_i & ~wr_i & in_map;
  assign rd_reg_o = reg_e'(idx[3:0]);

  // R8: at most one register is written per access
  a_r8_one_write: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(wr_stb_o));
  // R10: a write never produces a read hit
  a_r10_no_rd_on_wr: assert property (@(posedge clk) disable iff (!rst_ni)
    (|wr_stb_o) |-> !rd_hit_o);
endmodule

// File: rtl/setclr_bitvec.sv
module setclr_bitvec #(
  parameter int W        = 8,
  parameter bit SET_WINS = 1'b0
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;
  logic         q_en;

  if (SET_WINS) begin : g_set_wins
    assign q_d = (q_o & ~clr_i) | set_i;
  end else begin : g_clr_wins
    assign q_d = (q_o | set_i) & ~clr_i;
  end

  assign q_en = |(set_i | clr_i);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (q_en) q_o <= q_d;
  end

  // R3/R4/R5: bits neither set nor cleared hold their value
  a_r3_untouched_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> ((q_o ^ $past(q_o)) & ~$past(set_i | clr_i)) == '0);
  // R3/R5: a set alone leaves the bit one
  a_r5_set_lands: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> (($past(set_i) & ~$past(clr_i)) & ~q_o) == '0);
  // R3/R4/R5: a clear alone leaves the bit zero
  a_r4_clr_lands: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> (($past(clr_i) & ~$past(set_i)) & q_o) == '0);
  if (SET_WINS) begin : g_chk_set
    // R4: a set colliding with a clear leaves the bit one
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_ni)
      1'b1 |=> ($past(set_i) & ~q_o) == '0);
  end else begin : g_chk_clr
    // R3: a clear colliding with a set leaves the bit zero
    a_r3_clr_wins: assert property (@(posedge clk) disable iff (!rst_ni)
      1'b1 |=> ($past(clr_i) & q_o) == '0);
  end
endmodule

// File: rtl/setclr_regbank.sv
module setclr_regbank
  import setclr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CMD_W  = 4,
  parameter int MODE_W = 8,
  parameter int FEAT_W = 8,
  parameter int EVT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [EVT_W-1:0]  evt_in,
  output logic [CMD_W-1:0]  cmd_pulse,
  output logic [MODE_W-1:0] mode_o,
  output logic [FEAT_W-1:0] feat_en,
  output logic              irq
);
  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic [NUM_REGS-1:0] wr_stb;
  logic                rd_hit;
  reg_e                rd_reg;

  setclr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .sel_i    (bus_sel),
    .wr_i     (bus_wr),
    .addr_i   (bus_addr),
    .wr_stb_o (wr_stb),
    .rd_hit_o (rd_hit),
    .rd_reg_o (rd_reg)
  );

  // Command pulses: next state, then register
  logic [CMD_W-1:0] cmd_d;
  always_comb cmd_d = wr_stb[RG_CMD] ? bus_wdata[CMD_W-1:0] : '0;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cmd_pulse <= '0;
    else         cmd_pulse <= cmd_d;
  end

  // Mode register with explicit enable
  logic [MODE_W-1:0] mode_d;
  logic              mode_en;
  always_comb begin
    mode_en = wr_stb[RG_MODE];
    mode_d  = bus_wdata[MODE_W-1:0];
  end
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      mode_o <= '0;
    else if (mode_en) mode_o <= mode_d;
  end

  // Feature enable: clear beats set
  logic [FEAT_W-1:0] fset, fclr;
  assign fset = wr_stb[RG_FSET] ? bus_wdata[FEAT_W-1:0] : '0;
  assign fclr = wr_stb[RG_FCLR] ? bus_wdata[FEAT_W-1:0] : '0;
  setclr_bitvec #(.W(FEAT_W), .SET_WINS(1'b0)) u_feat (
    .clk(clk), .rst_ni(rst_ni), .set_i(fset), .clr_i(fclr), .q_o(feat_en));

  // Event status: hardware set beats software clear
  logic [EVT_W-1:0] evst, eclr;
  assign eclr = wr_stb[RG_EVCLR] ? bus_wdata[EVT_W-1:0] : '0;
  setclr_bitvec #(.W(EVT_W), .SET_WINS(1'b1)) u_evst (
    .clk(clk), .rst_ni(rst_ni), .set_i(evt_in), .clr_i(eclr), .q_o(evst));

  // Interrupt mask: clear beats set
  logic [EVT_W-1:0] imask, mset, mclr;
  assign mset = wr_stb[RG_MSET] ? bus_wdata[EVT_W-1:0] : '0;
  assign mclr = wr_stb[RG_MCLR] ? bus_wdata[EVT_W-1:0] : '0;
  setclr_bitvec #(.W(EVT_W), .SET_WINS(1'b0)) u_mask (
    .clk(clk), .rst_ni(rst_ni), .set_i(mset), .clr_i(mclr), .q_o(imask));

  assign irq = |(evst & imask);

  // Read mux: unused bits, write-only and unmapped offsets read zero
  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      unique case (rd_reg)
        RG_MODE:  bus_rdata[MODE_W-1:0] = mode_o;
        RG_FSTAT: bus_rdata[FEAT_W-1:0] = feat_en;
        RG_EVST:  bus_rdata[EVT_W-1:0]  = evst;
        RG_MASK:  bus_rdata[EVT_W-1:0]  = imask;
        default:  bus_rdata             = '0;
      endcase
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  // R1: a pulse lasts one cycle unless the command register is written again
  a_r1_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_ni)
    ((|cmd_pulse) && !wr_stb[RG_CMD]) |=> (cmd_pulse == '0));
  // R2: mode changes only on a mode write
  a_r2_mode_stable: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_stb[RG_MODE] |=> $stable(mode_o));
  // R6: no interrupt without both a pending event and a mask bit
  a_r6_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> ((imask != '0) && (evst != '0)));
  // R10: no read presented, no read data
  a_r10_idle_rdata: assert property (@(posedge clk) disable iff (!rst_ni)
    (!bus_sel || bus_wr) |-> (bus_rdata == '0));
endmodule

// File: tb/setclr_regbank_test.sv
`timescale 1ns/1ps
module setclr_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  evt_in;
  logic [3:0]  cmd_pulse;
  logic [7:0]  mode_o, feat_en;
  logic        irq;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  setclr_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .cmd_pulse(cmd_pulse), .mode_o(mode_o),
    .feat_en(feat_en), .irq(irq));

  always #4 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, write at the next posedge, return at the following negedge.
  task automatic wr(logic [7:0] a, logic [31:0] d, logic [7:0] ev = 8'h00);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; evt_in = ev;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; evt_in = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic event_pulse(logic [7:0] ev);
    evt_in = ev;
    @(posedge clk); @(negedge clk);
    evt_in = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R9 cmd", {28'd0, cmd_pulse}, 0);
    check("R9 mode_o", {24'd0, mode_o}, 0);
    check("R9 feat_en", {24'd0, feat_en}, 0);
    check("R9 irq", {31'd0, irq}, 0);
    for (int i = 0; i < 10; i++) begin
      rd(8'(i * 4), d);
      check("R9 reg read", d, 0);
    end
  endtask

  task automatic t_cmd;
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFF5);
    check("R1 pulse", {28'd0, cmd_pulse}, 32'h5);
    @(negedge clk);
    check("R1 pulse ends", {28'd0, cmd_pulse}, 0);
    wr(8'h00, 32'h0);
    check("R1 zero write", {28'd0, cmd_pulse}, 0);
    rd(8'h00, d);
    check("R1 read zero", d, 0);
  endtask

  task automatic t_mode;
    logic [31:0] d;
    wr(8'h04, 32'hFFFF_FFA5);
    rd(8'h04, d);
    check("R2 readback", d, 32'hA5);
    check("R2 mode_o", {24'd0, mode_o}, 32'hA5);
  endtask

  task automatic t_feat;
    logic [31:0] d;
    wr(8'h08, 32'h0F);
    rd(8'h10, d); check("R3 set", d, 32'h0F);
    wr(8'h08, 32'h30);
    rd(8'h10, d); check("R3 zeros ignored on set", d, 32'h3F);
    wr(8'h0C, 32'h05);
    rd(8'h10, d); check("R3 clear", d, 32'h3A);
    check("R3 feat_en", {24'd0, feat_en}, 32'h3A);
    rd(8'h08, d); check("R8 write-only read", d, 0);
    wr(8'h10, 32'hFF);
    rd(8'h10, d); check("R8 read-only write ignored", d, 32'h3A);
  endtask

  task automatic t_event;
    logic [31:0] d;
    event_pulse(8'h81);
    rd(8'h14, d); check("R4 hw set", d, 32'h81);
    wr(8'h14, 32'hFF);
    rd(8'h14, d); check("R8 status write ignored", d, 32'h81);
    wr(8'h18, 32'h01);
    rd(8'h14, d); check("R4 clear", d, 32'h80);
    wr(8'h18, 32'h02, 8'h02);
    rd(8'h14, d); check("R4 set beats clear", d, 32'h82);
    wr(8'h18, 32'hFF);
    rd(8'h14, d); check("R4 clear all", d, 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(8'h1C, 32'h04);
    rd(8'h24, d); check("R5 mask set", d, 32'h04);
    check("R6 no event", {31'd0, irq}, 0);
    event_pulse(8'h04);
    check("R6 irq up", {31'd0, irq}, 1);
    wr(8'h20, 32'h04);
    check("R6 masked off", {31'd0, irq}, 0);
    rd(8'h24, d); check("R5 mask clear", d, 0);
    rd(8'h14, d); check("R6 status kept", d, 32'h04);
    wr(8'h1C, 32'h04);
    check("R6 unmask", {31'd0, irq}, 1);
    event_pulse(8'h10);
    check("R6 unmasked event no change", {31'd0, irq}, 1);
    wr(8'h18, 32'h04);
    check("R6 clear drops irq", {31'd0, irq}, 0);
    rd(8'h1C, d); check("R8 mask-set read zero", d, 0);
  endtask

  task automatic t_subword;
    logic [31:0] d;
    wr(8'h07, 32'h3C);
    rd(8'h05, d); check("R7 low bits ignored", d, 32'h3C);
    rd(8'h06, d); check("R7 half-word offset", d, 32'h3C);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, d); check("R8 unmapped read", d, 0);
    rd(8'h04, d); check("R8 unmapped write no effect", d, 32'h3C);
    rd(8'h28, d); check("R8 first unmapped", d, 0);
  endtask

  task automatic t_idle;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 8'h04;
    #1 check("R10 no select", bus_rdata, 0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h40; bus_wdata = '0;
    #1 check("R10 write cycle", bus_rdata, 0);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; evt_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_cmd();
    t_mode();
    t_feat();
    t_event();
    t_irq();
    t_subword();
    t_unmapped();
    t_idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule